// File: doc/BRIEF.md
# Boundary Scan Cell Chain

This block is a chain of boundary scan cells that sits between the core logic and the chip pins. It has three kinds of cell. Input cells sit between a pin and the core. Output cells sit between the core and a 2-state or 3-state output pin. Enable cells each gate the output enable of one group of 3-state pins. Every cell holds a capture/shift flip-flop and an update register. The shift flip-flops form one serial path from `tdi_i` to `tdo_o`.

The scan strobes come from a test access controller, which is outside this block. `capture_i` loads the shift stages in parallel on the rising `tck_i` edge, and `shift_i` moves data one cell toward `tdo_o` on the rising edge. `update_i` copies the shift stages into the update registers on the falling edge. `mode_i` chooses the cell outputs. At 0 the system values pass straight through, which serves normal operation and sample/preload. At 1 the update registers drive both the pins and the core inputs, which serves the external interconnect test.

The chain is ordered from `tdo_o` toward `tdi_i`: the input cells first, then the 2-state output cells, then the 3-state data cells, then the enable cells. The cell at position 0 is shifted out first.

Top module: `bsr_chain`

## Requirements
- R1: With `mode_i`=0, `core_in_o` equals `pin_in_i`, `pad_out_o` equals `core_out_i`, and 3-state pin j has `pad_oe_o[j]` equal to `core_oe_i[j/(N_TRI/N_GRP)]`.
- R2: A rising `tck_i` edge with `shift_i`=1 and `capture_i`=0 moves every shift stage one position toward `tdo_o`. Position L-1 takes `tdi_i`, and `tdo_o` shows position 0. A pattern shifted in therefore comes out unchanged L shifts later.
- R3: A rising edge with `capture_i`=1 loads the shift stages in parallel. Positions 0..N_IN-1 take `pin_in_i`. Positions N_IN..N_IN+N_OUT-1 take the `pad_out_o` bit they drive. The last N_GRP positions take the enable value their group is driving. With `mode_i`=0 this samples live values and leaves normal operation undisturbed.
- R4: The update registers change only on a falling `tck_i` edge with `update_i`=1. Shifting and capture leave `pad_out_o`, `pad_oe_o` and, in test mode, `core_in_o` unchanged.
- R5: With `mode_i`=1, `pad_out_o` and `core_in_o` show the update registers of their cells, and changes on `core_out_i` or `pin_in_i` have no effect on them.
- R6: Values preloaded with `mode_i`=0 appear on the pins as soon as `mode_i` goes to 1, and an external test capture then returns the looped-back pin values at the input positions.
- R7: With `mode_i`=1, the update register of enable cell g (position N_IN+N_OUT+g, 1 = drive) sets `pad_oe_o` for all N_TRI/N_GRP pins of group g together.
- R8: An active-low `rst_ni` clears all shift stages and update registers at once. With `mode_i`=1 all 3-state pins are then disabled and `tdo_o` reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck_i | input | 1 | Test clock; capture/shift on rise, update on fall |
| rst_ni | input | 1 | Asynchronous active-low reset of the test logic |
| tdi_i | input | 1 | Serial data into position L-1 |
| capture_i | input | 1 | Parallel capture strobe |
| shift_i | input | 1 | Shift strobe |
| update_i | input | 1 | Update strobe |
| mode_i | input | 1 | 0 = pass-through, 1 = update registers drive |
| core_out_i | input | N_OUT | Core data toward the output pins (2-state first, then 3-state) |
| core_oe_i | input | N_GRP | Core output enable for each 3-state group |
| pin_in_i | input | N_IN | Values at the input pins |
| core_in_o | output | N_IN | Input values presented to the core |
| pad_out_o | output | N_OUT | Data to the output pad drivers |
| pad_oe_o | output | N_TRI | Enable to the 3-state pad drivers |
| tdo_o | output | 1 | Serial data out of position 0 |

## Verification
The assertions assume that capture has priority whenever `capture_i` and `shift_i` are both high, and that `update_i` changes only after a rising edge. Under these conditions, each falling edge sees one stable value of `update_i`. The stimulus changes every strobe and data input 1 ns after a rising edge and never raises `capture_i` and `shift_i` together. As a result, each update and capture falls in exactly one known edge. The pin loop in the bench is combinational, so a captured pin value always reflects the outputs that the update registers are driving at that moment.

// File: rtl/bsr_pkg.sv
package bsr_pkg;
  typedef enum logic [1:0] {
    CK_IN  = 2'd0,
    CK_OUT = 2'd1,
    CK_EN  = 2'd2
  } cell_kind_e;
endpackage

// File: rtl/bsr_cell.sv
module bsr_cell #(
  parameter bsr_pkg::cell_kind_e KIND = bsr_pkg::CK_IN
) (
  input  logic tck_i,
  input  logic rst_ni,
  input  logic capture_i,
  input  logic shift_i,
  input  logic update_i,
  input  logic mode_i,
  input  logic sys_i,
  input  logic scan_i,
  output logic scan_o,
  output logic out_o
);
  logic sh_q, upd_q, cap_src;

  assign out_o   = mode_i ? upd_q : sys_i;
  // input cells sample the pin; output and enable cells sample what they drive
  assign cap_src = (KIND == bsr_pkg::CK_IN) ? sys_i : out_o;
  assign scan_o  = sh_q;

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni)        sh_q <= 1'b0;
    else if (capture_i) sh_q <= cap_src;
    else if (shift_i)   sh_q <= scan_i;
  end

  // update stage on falling edge; reset value 0 keeps enables inactive
  always_ff @(negedge tck_i or negedge rst_ni) begin
    if (!rst_ni)       upd_q <= 1'b0;
    else if (update_i) upd_q <= sh_q;
  end

  a_r4_upd_hold: assert property (@(negedge tck_i) disable iff (!rst_ni)
    !update_i |=> $stable(upd_q));

  a_r3_capture_src: assert property (@(posedge tck_i) disable iff (!rst_ni)
    capture_i |=> sh_q == $past(cap_src));
endmodule

// File: rtl/bsr_oe_fanout.sv
module bsr_oe_fanout #(
  parameter int N_TRI = 4,
  parameter int N_GRP = 2
) (
  input  logic [N_GRP-1:0] en_i,
  output logic [N_TRI-1:0] oe_o
);
  localparam int PER = N_TRI / N_GRP;

  for (genvar j = 0; j < N_TRI; j++) begin : g_pin
    assign oe_o[j] = en_i[j / PER];
  end

  initial begin
    a_r7_group_size: assert (PER * N_GRP == N_TRI && PER > 0);
  end
endmodule

// File: rtl/bsr_chain.sv
module bsr_chain #(
  parameter int N_IN   = 4,
  parameter int N_OUT2 = 2,
  parameter int N_TRI  = 4,
  parameter int N_GRP  = 2
) (
  input  logic              tck_i,
  input  logic              rst_ni,
  input  logic              tdi_i,
  input  logic              capture_i,
  input  logic              shift_i,
  input  logic              update_i,
  input  logic              mode_i,
  input  logic [N_OUT2+N_TRI-1:0] core_out_i,
  input  logic [N_GRP-1:0]  core_oe_i,
  input  logic [N_IN-1:0]   pin_in_i,
  output logic [N_IN-1:0]   core_in_o,
  output logic [N_OUT2+N_TRI-1:0] pad_out_o,
  output logic [N_TRI-1:0]  pad_oe_o,
  output logic              tdo_o
);
  localparam int N_OUT = N_OUT2 + N_TRI;
  localparam int B_OUT = N_IN;
  localparam int B_EN  = N_IN + N_OUT;
  localparam int L     = B_EN + N_GRP;

  logic [L-1:0]     sq;
  logic [L-1:0]     nxt;
  logic [N_GRP-1:0] grp_en;

  for (genvar k = 0; k < L; k++) begin : g_link
    if (k == L-1) begin : g_head
      assign nxt[k] = tdi_i;
    end else begin : g_mid
      assign nxt[k] = sq[k+1];
    end
  end

  for (genvar i = 0; i < N_IN; i++) begin : g_in
    bsr_cell #(.KIND(bsr_pkg::CK_IN)) u_cell (
      .tck_i, .rst_ni, .capture_i, .shift_i, .update_i, .mode_i,
      .sys_i(pin_in_i[i]), .scan_i(nxt[i]), .scan_o(sq[i]),
      .out_o(core_in_o[i]));
  end

  for (genvar o = 0; o < N_OUT; o++) begin : g_out
    bsr_cell #(.KIND(bsr_pkg::CK_OUT)) u_cell (
      .tck_i, .rst_ni, .capture_i, .shift_i, .update_i, .mode_i,
      .sys_i(core_out_i[o]), .scan_i(nxt[B_OUT+o]), .scan_o(sq[B_OUT+o]),
      .out_o(pad_out_o[o]));
  end

  for (genvar g = 0; g < N_GRP; g++) begin : g_en
    bsr_cell #(.KIND(bsr_pkg::CK_EN)) u_cell (
      .tck_i, .rst_ni, .capture_i, .shift_i, .update_i, .mode_i,
      .sys_i(core_oe_i[g]), .scan_i(nxt[B_EN+g]), .scan_o(sq[B_EN+g]),
      .out_o(grp_en[g]));
  end

  bsr_oe_fanout #(.N_TRI(N_TRI), .N_GRP(N_GRP)) u_fan (
    .en_i(grp_en), .oe_o(pad_oe_o));

  assign tdo_o = sq[0];

  a_r2_shift_step: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (shift_i && !capture_i) |=> tdo_o == $past(sq[1]));

  a_r2_shift_head: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (shift_i && !capture_i) |=> sq[L-1] == $past(tdi_i));

  a_r1_normal_in: assert property (@(posedge tck_i) disable iff (!rst_ni)
    !mode_i |-> core_in_o == pin_in_i);

  a_r7_group_off: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (mode_i && !g_en[0].u_cell.upd_q) |-> pad_oe_o[N_TRI/N_GRP-1:0] == '0);
endmodule

// File: tb/sim_bsr_chain.sv
module sim_bsr_chain;
  localparam int NI = 4, NO2 = 2, NT = 4, NG = 2;
  localparam int NO = NO2 + NT, L = NI + NO + NG;

  logic tck = 0, rst_n = 0, tdi = 0, cap = 0, sh = 0, upd = 0, mode = 0;
  logic [NO-1:0] core_out = '0;
  logic [NG-1:0] core_oe = '0;
  logic [NI-1:0] pin_flip = '0;
  logic [NI-1:0] pin_in, core_in;
  logic [NO-1:0] pad_out;
  logic [NT-1:0] pad_oe;
  logic tdo;
  int checks = 0, errors = 0;

  always #4 tck = ~tck;

  // pin loop: out2 -> in0/in1, tri0 -> in2, tri2 -> in3, pull-up when disabled
  assign pin_in[0] = pad_out[0] ^ pin_flip[0];
  assign pin_in[1] = pad_out[1] ^ pin_flip[1];
  assign pin_in[2] = (pad_oe[0] ? pad_out[2] : 1'b1) ^ pin_flip[2];
  assign pin_in[3] = (pad_oe[2] ? pad_out[4] : 1'b1) ^ pin_flip[3];

  bsr_chain #(.N_IN(NI), .N_OUT2(NO2), .N_TRI(NT), .N_GRP(NG)) u0 (
    .tck_i(tck), .rst_ni(rst_n), .tdi_i(tdi), .capture_i(cap), .shift_i(sh),
    .update_i(upd), .mode_i(mode), .core_out_i(core_out), .core_oe_i(core_oe),
    .pin_in_i(pin_in), .core_in_o(core_in), .pad_out_o(pad_out),
    .pad_oe_o(pad_oe), .tdo_o(tdo));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge tck); #1;
  endtask

  task automatic shift_vec(input logic [L-1:0] vin, output logic [L-1:0] vout);
    sh = 1;
    for (int j = 0; j < L; j++) begin
      vout[j] = tdo;
      tdi = vin[j];
      tick();
    end
    sh = 0;
  endtask

  task automatic do_update();
    upd = 1; tick(); upd = 0;
  endtask

  task automatic do_capture();
    cap = 1; tick(); cap = 0;
  endtask

  function automatic logic [NT-1:0] oe_of(input logic [NG-1:0] e);
    return {e[1], e[1], e[0], e[0]};
  endfunction

  function automatic logic [NI-1:0] loop_of(input logic [NO-1:0] d, input logic [NT-1:0] oe);
    return {oe[2] ? d[4] : 1'b1, oe[0] ? d[2] : 1'b1, d[1], d[0]};
  endfunction

  task automatic t_reset();
    chk("R8 tdo after reset", tdo, 0);
    mode = 1; #1;
    chk("R8 oe after reset", pad_oe, 0);
    chk("R8 out after reset", pad_out, 0);
    mode = 0; #1;
  endtask

  task automatic t_normal();
    core_out = 6'b101101; core_oe = 2'b01; #1;
    chk("R1 pad_out pass", pad_out, 6'b101101);
    chk("R1 pad_oe pass", pad_oe, 4'b0011);
    chk("R1 core_in pass", core_in, loop_of(6'b101101, 4'b0011));
    core_out = 6'b010010; core_oe = 2'b10; #1;
    chk("R1 pad_oe pass 2", pad_oe, 4'b1100);
    chk("R1 core_in pass 2", core_in, loop_of(6'b010010, 4'b1100));
  endtask

  task automatic t_shift();
    logic [L-1:0] got;
    shift_vec(12'hA5C, got);
    shift_vec(12'h3F1, got);
    chk("R2 shift through", got, 12'hA5C);
    shift_vec(12'h000, got);
    chk("R2 shift through 2", got, 12'h3F1);
  endtask

  task automatic t_sample();
    logic [L-1:0] got, e;
    core_out = 6'b100111; core_oe = 2'b01; #1;
    do_capture();
    chk("R3 sample keeps pins", pad_out, 6'b100111);
    shift_vec('0, got);
    e = {2'b01, 6'b100111, loop_of(6'b100111, oe_of(2'b01))};
    chk("R3 sample capture", got, e);
  endtask

  task automatic t_extest();
    logic [L-1:0] got, v;
    // enable both groups, data 110101, input cells 1010
    v = {2'b11, 6'b110101, 4'b1010};
    shift_vec(v, got);
    do_update();
    chk("R5 normal still passes before mode", pad_out, core_out);
    mode = 1; #1;
    chk("R6 preload drives pins", pad_out, 6'b110101);
    chk("R7 both groups on", pad_oe, 4'b1111);
    chk("R5 core isolated", core_in, 4'b1010);
    core_out = ~core_out; pin_flip = 4'b1111; #1;
    chk("R5 core_out ignored", pad_out, 6'b110101);
    chk("R5 pin ignored by core", core_in, 4'b1010);
    pin_flip = '0; #1;
    do_capture();
    shift_vec('0, got);
    chk("R6 extest capture inputs", got[NI-1:0], loop_of(6'b110101, 4'b1111));
    chk("R3 extest capture outputs", got[L-1:NI], {2'b11, 6'b110101});
  endtask

  task automatic t_group_hold();
    logic [L-1:0] got, v;
    v = {2'b10, 6'b011111, 4'b0000};
    sh = 1;
    for (int j = 0; j < L; j++) begin
      tdi = v[j]; tick();
      checks++;
      if (pad_out !== 6'b110101 || pad_oe !== 4'b1111) begin
        errors++;
        $display("FAIL R4 hold during shift act=%h/%h exp=35/f", pad_out, pad_oe);
      end
    end
    sh = 0;
    do_capture();
    chk("R4 hold after capture", pad_out, 6'b110101);
    shift_vec(v, got);
    do_update();
    chk("R7 group0 off", pad_oe, 4'b1100);
    chk("R7 pullup on disabled pin", pin_in[2], 1'b1);
    chk("R6 enabled loop", pin_in[3], 1'b1);
    chk("R6 new data", pad_out, 6'b011111);
  endtask

  task automatic t_reset_mid();
    rst_n = 0; #2;
    chk("R8 async oe clear", pad_oe, 0);
    chk("R8 async tdo clear", tdo, 0);
    chk("R8 async core_in", core_in, 0);
    rst_n = 1; tick();
    mode = 0;
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog act=running exp=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #10; rst_n = 1; tick();
    t_reset();
    t_normal();
    t_shift();
    t_sample();
    t_extest();
    t_group_hold();
    t_reset_mid();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule